// File: doc/BRIEF.md
# Command Buffer Sequencer with Subroutine Call

This block reads a list of 64-bit instructions from memory and runs them in order. It starts at a head address and stops when it reaches a tail address. It knows three instructions: a NOP, a register write and a call. The call runs a second instruction list, which may sit anywhere in memory, and then returns to the instruction just after the call. The return address is held in a single register, so only one level of call is allowed.

Memory is built from 64-byte lines, each holding eight quadword slots. The call instruction carries the head and tail of the subroutine, each stored as a line number: the byte address shifted right by six. Its position is restricted. A call may not sit in either of the last two slots of a line. Every quadword after the call, up to the end of that line, must be zero. The block checks both rules while it runs. It raises a sticky error flag and stops as soon as it finds an instruction that is not allowed.

Memory reads use a request/valid handshake with any latency. Register writes come out as a one-cycle strobe that carries an offset and a data word.

Top module: `cmdseq_top`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, err, wr_en and mem_req are all low.
- R2: A start pulse while the block is idle loads head_addr and tail_addr and begins fetching at head_addr. A start pulse while busy is ignored.
- R3: A quadword that is all zero is a NOP. It has no effect except to move the fetch address on by 8.
- R4: A quadword whose bits [63:56] are 0x01 is a register write. It gives exactly one cycle of wr_en, with wr_offset taken from bits [55:32] and wr_data from bits [31:0].
- R5: While a read is outstanding, mem_req stays high and mem_addr stays unchanged until the cycle in which mem_valid is seen. The sequencer makes no other progress during that time.
- R6: A quadword whose bits [63:56] are 0x0C is a call. Bits [51:26] hold the subroutine head and bits [25:0] hold the subroutine tail, each as a byte address shifted right by 6. Bits [55:52] are ignored. After a call, fetching continues at the subroutine head. The subroutine runs up to its tail, and the tail address itself is not fetched. Fetching then resumes at the call address plus 8.
- R7: A call fetched from slot 6 or 7 of its line (address bits [5:3] equal to 6 or 7) raises err and stops the block without jumping. A call in slot 5 is legal.
- R8: After a return, every quadword from the call address plus 8 up to the end of the call's 64-byte line must be zero. Any non-zero quadword there raises err and stops the block.
- R9: A call fetched while a subroutine is running raises err and stops the block.
- R10: Any other non-zero quadword raises err and stops the block. This covers any opcode other than 0x01 and 0x0C, including opcode 0x00 with non-zero low bits.
- R11: When the fetch address equals the top-level tail and no subroutine is running, done pulses high for one cycle and busy drops. If the head equals the tail, no fetch takes place before done.
- R12: err stays high until the next accepted start pulse, which clears it. No register write is issued after err rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running a buffer (only accepted while idle) |
| head_addr | input | 32 | Byte address of the first instruction (line aligned) |
| tail_addr | input | 32 | Byte address just past the last instruction (line aligned) |
| mem_req | output | 1 | Read request, held until mem_valid |
| mem_addr | output | 32 | Byte address of the requested quadword |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 64 | Returned quadword |
| wr_en | output | 1 | One-cycle register-write strobe |
| wr_offset | output | 24 | Register offset for the write |
| wr_data | output | 32 | Data for the write |
| busy | output | 1 | A buffer is being run |
| done | output | 1 | One-cycle pulse when the top-level tail is reached |
| err | output | 1 | Sticky error flag |

## Verification
The hardest case to reach is the check on the rest of the call's line. It only applies after a subroutine has been entered, run to its tail and left again, and it covers only the quadwords left in that line. The stimulus builds a caller with a call in slot 2 that jumps to a subroutine containing writes, followed by a register write in slot 3. The expected result is the subroutine's writes and then an error. A second caller puts the call in slot 5, with zeros after it, and must finish cleanly. The memory model changes its response latency on every read, so each of these paths is also run while the sequencer waits a different number of cycles for each fetch.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam logic [7:0] OP_REGWR = 8'h01;
  localparam logic [7:0] OP_CALL  = 8'h0C;

  typedef enum logic [1:0] {
    K_NOP,
    K_WR,
    K_CALL,
    K_BAD
  } ikind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EXEC
  } seq_st_t;

endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 24,
  parameter int LINE_SHIFT = 6,
  parameter int SLOT_W     = 3,
  parameter int LAST_CALL  = 5
) (
  input  logic [63:0]        instr,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               in_sub,
  input  logic               pad_zone,
  output ikind_t             kind,
  output logic [OFS_W-1:0]   wr_ofs,
  output logic [31:0]        wr_dat,
  output logic [ADDR_W-1:0]  sub_head,
  output logic [ADDR_W-1:0]  sub_tail
);

  localparam int PTR_W = ADDR_W - LINE_SHIFT;

  logic [7:0] op;
  logic       is_zero;
  logic       slot_ok;

  assign op      = instr[63:56];
  assign is_zero = (instr == 64'd0);
  assign slot_ok = (slot <= SLOT_W'(LAST_CALL));

  assign wr_ofs   = instr[32 +: OFS_W];
  assign wr_dat   = instr[31:0];
  assign sub_head = {instr[PTR_W +: PTR_W], {LINE_SHIFT{1'b0}}};
  assign sub_tail = {instr[0 +: PTR_W], {LINE_SHIFT{1'b0}}};

  always_comb begin
    kind = K_BAD;
    if (pad_zone) begin
      kind = is_zero ? K_NOP : K_BAD;
    end else if (is_zero) begin
      kind = K_NOP;
    end else if (op == OP_REGWR) begin
      kind = K_WR;
    end else if (op == OP_CALL) begin
      kind = (in_sub || !slot_ok) ? K_BAD : K_CALL;
    end
  end

endmodule

// File: rtl/cmdseq_fetch.sv
module cmdseq_fetch #(
  parameter int ADDR_W = 32,
  parameter int QW_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [QW_W-1:0]   mem_rdata,
  output logic              got,
  output logic [QW_W-1:0]   qword
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      got      <= 1'b0;
      qword    <= '0;
    end else begin
      got <= 1'b0;
      if (issue) begin
        mem_req  <= 1'b1;
        mem_addr <= addr;
      end else if (mem_req && mem_valid) begin
        mem_req <= 1'b0;
        qword   <= mem_rdata;
        got     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 24,
  parameter int LINE_BYTES = 64,
  parameter int QW_BYTES   = 8,
  parameter int LAST_CALL  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [ADDR_W-1:0] tail_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [63:0]       mem_rdata,
  output logic              wr_en,
  output logic [OFS_W-1:0]  wr_offset,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int QW_SHIFT   = $clog2(QW_BYTES);
  localparam int SLOT_W     = LINE_SHIFT - QW_SHIFT;

  seq_st_t           st;
  logic [ADDR_W-1:0] pc, top_tail, sub_end, ret_pc, pc_next;
  logic              in_sub, pad_zone;
  logic              at_sub_end, at_top_end, issue, got;
  logic [63:0]       qword;
  ikind_t            kind;
  logic [OFS_W-1:0]  d_ofs;
  logic [31:0]       d_dat;
  logic [ADDR_W-1:0] d_head, d_tail;

  assign pc_next    = pc + ADDR_W'(QW_BYTES);
  assign at_sub_end = in_sub && (pc == sub_end);
  assign at_top_end = !in_sub && (pc == top_tail);
  assign issue      = (st == ST_FETCH) && !at_sub_end && !at_top_end;

  cmdseq_fetch #(.ADDR_W(ADDR_W), .QW_W(64)) u_fetch (
    .clk(clk), .rst(rst), .issue(issue), .addr(pc),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .got(got), .qword(qword)
  );

  cmdseq_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_SHIFT(LINE_SHIFT),
    .SLOT_W(SLOT_W), .LAST_CALL(LAST_CALL)
  ) u_dec (
    .instr(qword), .slot(pc[LINE_SHIFT-1:QW_SHIFT]),
    .in_sub(in_sub), .pad_zone(pad_zone),
    .kind(kind), .wr_ofs(d_ofs), .wr_dat(d_dat),
    .sub_head(d_head), .sub_tail(d_tail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pc        <= '0;
      top_tail  <= '0;
      sub_end   <= '0;
      ret_pc    <= '0;
      in_sub    <= 1'b0;
      pad_zone  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      wr_en     <= 1'b0;
      wr_offset <= '0;
      wr_data   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            pc       <= head_addr;
            top_tail <= tail_addr;
            in_sub   <= 1'b0;
            pad_zone <= 1'b0;
            err      <= 1'b0;
            busy     <= 1'b1;
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (at_sub_end) begin
            pc       <= ret_pc;
            in_sub   <= 1'b0;
            pad_zone <= (ret_pc[LINE_SHIFT-1:0] != '0);
          end else if (at_top_end) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (got) st <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (kind)
            K_NOP: begin
              pc       <= pc_next;
              pad_zone <= pad_zone && (pc_next[LINE_SHIFT-1:0] != '0);
              st       <= ST_FETCH;
            end
            K_WR: begin
              wr_en     <= 1'b1;
              wr_offset <= d_ofs;
              wr_data   <= d_dat;
              pc        <= pc_next;
              st        <= ST_FETCH;
            end
            K_CALL: begin
              ret_pc  <= pc_next;
              pc      <= d_head;
              sub_end <= d_tail;
              in_sub  <= 1'b1;
              st      <= ST_FETCH;
            end
            default: begin
              err  <= 1'b1;
              busy <= 1'b0;
              st   <= ST_IDLE;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              wr_en,
  input logic              busy,
  input logic              done,
  input logic              err
);

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R5

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[2:0] == 3'd0)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !err)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err); // R12

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(err && busy)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !wr_en)); // R12

endmodule

bind cmdseq_top cmdseq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_valid(mem_valid), .wr_en(wr_en),
  .busy(busy), .done(done), .err(err)
);

// File: tb/test_cmdseq_top.sv
module test_cmdseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] head = '0, tail = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        wr_en, busy, done, err;
  logic [23:0] wr_offset;
  logic [31:0] wr_data;

  always #2 clk = ~clk;

  cmdseq_top i_cmdseq_top (
    .clk(clk), .rst(rst), .start(start), .head_addr(head), .tail_addr(tail),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_offset(wr_offset),
    .wr_data(wr_data), .busy(busy), .done(done), .err(err)
  );

  int n_cmp = 0, n_bad = 0;
  logic [63:0] mem [0:255];
  logic [55:0] exp_q[$];
  string cur_req = "R4";
  bit seen_done = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_wr(input logic [23:0] o, input logic [31:0] d);
    return {8'h01, o, d};
  endfunction

  function automatic logic [63:0] mk_call(input logic [31:0] h, input logic [31:0] t);
    return {8'h0C, 4'h0, h[31:6], t[31:6]};
  endfunction

  task automatic put(input logic [31:0] a, input logic [63:0] q);
    mem[a[10:3]] = q;
  endtask

  task automatic expect_wr(input logic [23:0] o, input logic [31:0] d);
    exp_q.push_back({o, d});
  endtask

  // memory responder with varying latency, plus R5 hold check
  int lat = 0, seed = 0, r5_obs = 0;
  bit pend = 0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_valid = 1'b0;
      pend = 0;
    end else begin
      if (pend && mem_req) begin
        r5_obs++;
        if (mem_addr != pend_addr) chk(0, "R5", "address changed while waiting", {32'd0, mem_addr}, {32'd0, pend_addr});
      end
      if (mem_valid) mem_valid = 1'b0;
      else if (mem_req) begin
        if (lat == 0) begin
          mem_valid = 1'b1;
          mem_rdata = mem[mem_addr[10:3]];
          seed++;
          lat = seed % 4;
        end else lat--;
      end
      pend = mem_req && !mem_valid;
      pend_addr = mem_addr;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) seen_done = 1;
      if (wr_en) begin
        if (exp_q.size() == 0)
          chk(0, cur_req, "unexpected write", {8'd0, wr_offset, wr_data}, 64'd0);
        else begin
          logic [55:0] e;
          e = exp_q.pop_front();
          chk({wr_offset, wr_data} == e, cur_req, "write content", {8'd0, wr_offset, wr_data}, {8'd0, e});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic pulse_start(input logic [31:0] h, input logic [31:0] t);
    @(negedge clk);
    head = h; tail = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input bit exp_err, input string req);
    for (int i = 0; i < 3000 && !seen_done && !err; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(err == exp_err, req, "err outcome", {63'd0, err}, {63'd0, exp_err});
    chk(seen_done == !exp_err, req, "done outcome", {63'd0, seen_done}, {63'd0, !exp_err});
    chk(busy == 1'b0, req, "busy after end", {63'd0, busy}, 64'd0);
    chk(exp_q.size() == 0, req, "writes left unseen", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  task automatic run(input logic [31:0] h, input logic [31:0] t,
                     input bit exp_err, input string req);
    cur_req = req;
    seen_done = 0;
    pulse_start(h, t);
    finish_run(exp_err, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 64'd0;
    // plain program, line 0x000
    put(32'h000, mk_wr(24'h000010, 32'h11111111));
    put(32'h010, mk_wr(24'hABCDEF, 32'hDEADBEEF));
    // caller 0x100: write, call in slot 1, then next line write
    put(32'h100, mk_wr(24'h000100, 32'hA0A0A0A0));
    put(32'h108, mk_call(32'h200, 32'h240));
    put(32'h140, mk_wr(24'h000103, 32'hD0D0D0D0));
    // subroutine 0x200..0x240, word at tail must not run
    put(32'h200, mk_wr(24'h000101, 32'hB0B0B0B0));
    put(32'h208, mk_wr(24'h000102, 32'hC0C0C0C0));
    put(32'h240, mk_wr(24'h0000FF, 32'hFFFFFFFF));
    // call in slot 6
    put(32'h300, mk_wr(24'h000200, 32'hE0E0E0E0));
    put(32'h330, mk_call(32'h200, 32'h240));
    // call in slot 2, non-zero in slot 3 after return
    put(32'h410, mk_call(32'h200, 32'h240));
    put(32'h418, mk_wr(24'h000300, 32'h0F0F0F0F));
    // nested call
    put(32'h480, mk_call(32'h500, 32'h540));
    put(32'h500, mk_wr(24'h000400, 32'h67676767));
    put(32'h508, mk_call(32'h200, 32'h240));
    // unknown opcode, then opcode 0 with non-zero bits
    put(32'h580, mk_wr(24'h000500, 32'h48484848));
    put(32'h588, 64'h0500_0000_0000_0001);
    put(32'h5C0, 64'h0000_0000_0000_0001);
    // call in slot 7
    put(32'h6F8, mk_call(32'h200, 32'h240));
    // call in slot 5 (legal), zeros after
    put(32'h728, mk_call(32'h200, 32'h240));
    // empty subroutine, call in slot 0
    put(32'h780, mk_call(32'h7C0, 32'h7C0));
    put(32'h788, 64'd0);

    repeat (3) @(negedge clk);
    chk({busy, done, err, wr_en, mem_req} == 5'd0, "R1", "outputs in reset",
        {59'd0, busy, done, err, wr_en, mem_req}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, err, wr_en, mem_req} == 5'd0, "R1", "outputs after reset",
        {59'd0, busy, done, err, wr_en, mem_req}, 64'd0);

    // R3 R4: NOPs and writes
    expect_wr(24'h000010, 32'h11111111);
    expect_wr(24'hABCDEF, 32'hDEADBEEF);
    run(32'h000, 32'h040, 0, "R4");

    // R6: call, subroutine, return; tail word not fetched
    expect_wr(24'h000100, 32'hA0A0A0A0);
    expect_wr(24'h000101, 32'hB0B0B0B0);
    expect_wr(24'h000102, 32'hC0C0C0C0);
    expect_wr(24'h000103, 32'hD0D0D0D0);
    run(32'h100, 32'h180, 0, "R6");

    // R7: call in slot 6
    expect_wr(24'h000200, 32'hE0E0E0E0);
    run(32'h300, 32'h340, 1, "R7");
    // R12: err sticky while idle
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R12", "err held while idle", {63'd0, err}, 64'd1);

    // R7: call in slot 7
    run(32'h6C0, 32'h700, 1, "R7");

    // R7: call in slot 5 is legal
    expect_wr(24'h000101, 32'hB0B0B0B0);
    expect_wr(24'h000102, 32'hC0C0C0C0);
    run(32'h700, 32'h740, 0, "R7");

    // R8: non-zero after return in the call's line
    expect_wr(24'h000101, 32'hB0B0B0B0);
    expect_wr(24'h000102, 32'hC0C0C0C0);
    run(32'h400, 32'h440, 1, "R8");

    // R9: nested call
    expect_wr(24'h000400, 32'h67676767);
    run(32'h480, 32'h4C0, 1, "R9");

    // R10: unknown opcode
    expect_wr(24'h000500, 32'h48484848);
    run(32'h580, 32'h5C0, 1, "R10");
    // R10: opcode 0 with low bit set
    run(32'h5C0, 32'h600, 1, "R10");

    // R11: head equals tail
    run(32'h600, 32'h600, 0, "R11");
    // R11 R6: empty subroutine returns at once
    run(32'h780, 32'h7C0, 0, "R11");

    // R2: start while busy is ignored; R12: accepted start clears err
    cur_req = "R2";
    seen_done = 0;
    expect_wr(24'h000010, 32'h11111111);
    expect_wr(24'hABCDEF, 32'hDEADBEEF);
    pulse_start(32'h000, 32'h040);
    chk(err == 1'b0, "R12", "err cleared by start", {63'd0, err}, 64'd0);
    chk(busy == 1'b1, "R2", "busy after start", {63'd0, busy}, 64'd1);
    repeat (3) @(negedge clk);
    pulse_start(32'h300, 32'h340);
    finish_run(0, "R2");

    chk(r5_obs > 0, "R5", "waits observed", 64'(r5_obs), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule